// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers a configurable number of peripheral interrupt lines (up to 32) and turns them into a single request line for a processor. When an input fires, the controller latches it into a status register. Each input is fixed at build time as either edge-sensitive or level-sensitive. The latched bits are masked by a per-input enable register. A two-bit master control gates the combined request.

Software works through a plain 32-bit register port. It reads the status, pending and enable words. It can change single enable bits without a read-modify-write, through separate set and clear registers. It acknowledges inputs by writing ones. A vector register, mirrored on an output port, returns the number of the lowest enabled pending input.

The register port has a word offset in address bits [4:2], a write strobe and a combinational read path. Address bits [1:0] are ignored.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, every register reads zero except the vector, which reads 0xFFFFFFFF, and `irq_req` is low.
- R2: An input whose bit in `EDGE_MASK` is 1 sets its status bit (offset 0x00) on each rising edge only. After acknowledge, the bit stays clear while the input remains high, until a new rising edge arrives.
- R3: An input whose `EDGE_MASK` bit is 0 sets its status bit in every cycle it is high. If it is still high when acknowledged, the bit stays set.
- R4: The status register captures inputs whether or not they are enabled.
- R5: Writing a mask to offset 0x0C clears the status bits written as 1 and leaves the other bits unchanged. A capture in the same cycle takes precedence.
- R6: A write to offset 0x08 loads the enable register. A write to 0x10 ORs the mask into it. A write to 0x14 clears the masked bits. Bits not in the mask are unchanged.
- R7: Offset 0x04 reads the status word ANDed with the enable word.
- R8: Offset 0x18 reads the index of the lowest-numbered pending input, or 0xFFFFFFFF if none is pending. Whenever `irq_req` is high, `irq_num` carries the same index.
- R9: Offset 0x1C holds two bits: bit 0 is the global enable and bit 1 is the processor-line enable. `irq_req` is high exactly when both bits are 1 and at least one input is pending.
- R10: Writes to 0x00, 0x04 and 0x18 change nothing. Reads of 0x0C, 0x10 and 0x14 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IN | Peripheral interrupt lines, synchronous to clk |
| bus_addr | input | ADDR_W | Byte address; bits [4:2] select the register |
| bus_wr | input | 1 | Write strobe, acts at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_num | output | IDX_W | Index of the lowest pending input |

## Verification
The bench builds the controller with 8 inputs and an edge mask of 0xF0, so inputs 0 to 3 are level-sensitive and inputs 4 to 7 are edge-sensitive. With only 8 inputs, every one of the 256 possible input patterns can be driven in turn. This checks the status capture, the pending word, the lowest-index vector and the request line for every pattern. Directed sequences then exercise both input kinds around acknowledge: a held level line that is acknowledged, and a held edge line that is acknowledged. They also cover the atomic enable updates, each combination of the two master bits, and the write-ignored and read-zero offsets.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        W_STATUS = 3'd0,
        W_PEND   = 3'd1,
        W_ENABLE = 3'd2,
        W_ACK    = 3'd3,
        W_SETEN  = 3'd4,
        W_CLREN  = 3'd5,
        W_VECTOR = 3'd6,
        W_MASTER = 3'd7
    } word_sel_e;

    typedef struct packed {
        logic line_en;
        logic glob_en;
    } master_t;

    function automatic logic gate_open(master_t m);
        return m.line_en & m.glob_en;
    endfunction
endpackage

// File: rtl/vic_capture.sv
module vic_capture #(
    parameter int NUM_IN = 32,
    parameter logic [NUM_IN-1:0] EDGE_MASK = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] lines,
    input  logic [NUM_IN-1:0] ack_mask,
    output logic [NUM_IN-1:0] status
);
    logic [NUM_IN-1:0] prev;
    logic [NUM_IN-1:0] hit;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_bit
        if (EDGE_MASK[i]) begin : g_edge
            assign hit[i] = lines[i] & ~prev[i];
        end else begin : g_level
            assign hit[i] = lines[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev   <= '0;
            status <= '0;
        end else begin
            prev   <= lines;
            status <= (status & ~ack_mask) | hit;
        end
    end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
    parameter int NUM_IN = 32,
    localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
    input  logic [NUM_IN-1:0] req,
    output logic              found,
    output logic [IDX_W-1:0]  idx
);
    always_comb begin
        idx = '1;
        for (int i = NUM_IN - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
        found = |req;
    end
endmodule

// File: rtl/vic_regs.sv
module vic_regs
    import vic_pkg::*;
#(
    parameter int NUM_IN = 32,
    parameter int ADDR_W = 5,
    localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_IN-1:0] status,
    input  logic [NUM_IN-1:0] pending,
    input  logic              found,
    input  logic [IDX_W-1:0]  idx,
    output logic [NUM_IN-1:0] enable,
    output logic [NUM_IN-1:0] ack_mask,
    output master_t           master
);
    word_sel_e         sel;
    logic [NUM_IN-1:0] wmask;
    logic [DATA_W-1:0] vec_word;

    assign sel      = word_sel_e'(bus_addr[4:2]);
    assign wmask    = bus_wdata[NUM_IN-1:0];
    assign ack_mask = (bus_wr && sel == W_ACK) ? wmask : '0;
    assign vec_word = found ? DATA_W'(idx) : '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= '0;
            master <= '0;
        end else if (bus_wr) begin
            case (sel)
                W_ENABLE: enable <= wmask;
                W_SETEN:  enable <= enable | wmask;
                W_CLREN:  enable <= enable & ~wmask;
                W_MASTER: master <= master_t'(bus_wdata[1:0]);
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            W_STATUS: bus_rdata = DATA_W'(status);
            W_PEND:   bus_rdata = DATA_W'(pending);
            W_ENABLE: bus_rdata = DATA_W'(enable);
            W_VECTOR: bus_rdata = vec_word;
            W_MASTER: bus_rdata = DATA_W'(master);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import vic_pkg::*;
#(
    parameter int NUM_IN = 32,
    parameter logic [NUM_IN-1:0] EDGE_MASK = '0,
    parameter int ADDR_W = 5,
    localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] irq_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_req,
    output logic [IDX_W-1:0]  irq_num
);
    logic [NUM_IN-1:0] status;
    logic [NUM_IN-1:0] enable;
    logic [NUM_IN-1:0] ack_mask;
    logic [NUM_IN-1:0] pending;
    logic              found;
    logic [IDX_W-1:0]  idx;
    master_t           master;

    vic_capture #(.NUM_IN(NUM_IN), .EDGE_MASK(EDGE_MASK)) u_cap (
        .clk(clk), .rst(rst), .lines(irq_in),
        .ack_mask(ack_mask), .status(status)
    );

    assign pending = status & enable;

    vic_prio #(.NUM_IN(NUM_IN)) u_prio (
        .req(pending), .found(found), .idx(idx)
    );

    vic_regs #(.NUM_IN(NUM_IN), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .status(status),
        .pending(pending), .found(found), .idx(idx), .enable(enable),
        .ack_mask(ack_mask), .master(master)
    );

    assign irq_req = found & gate_open(master);
    assign irq_num = idx;
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
    parameter int NUM_IN = 32,
    parameter int ADDR_W = 5,
    localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              irq_req,
    input logic [IDX_W-1:0]  irq_num,
    input logic [NUM_IN-1:0] status,
    input logic [NUM_IN-1:0] enable,
    input logic [1:0]        master
);
    a_r9_req_needs_master: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> master == 2'b11);

    a_r8_num_is_pending: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (status[irq_num] && enable[irq_num]));

    a_r6_set_enable: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr[4:2] == 3'd4) |=>
        enable == $past(enable | bus_wdata[NUM_IN-1:0]));

    a_r6_clear_enable: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr[4:2] == 3'd5) |=>
        enable == $past(enable & ~bus_wdata[NUM_IN-1:0]));

    a_r7_pending_read: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[4:2] == 3'd1) |-> bus_rdata == 32'(status & enable));

    a_r10_status_write_kept: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr[4:2] == 3'd0) |=> enable == $past(enable));
endmodule

bind irq_vector_ctrl vic_checker #(.NUM_IN(NUM_IN), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
    .irq_num(irq_num), .status(status), .enable(enable), .master(master)
);

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic        clk = 0;
    logic        rst = 1;
    logic [N-1:0] irq_in = '0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_req;
    logic [2:0]  irq_num;

    int tests = 0;
    int fails = 0;

    localparam logic [4:0] A_ST = 5'h00, A_PD = 5'h04, A_EN = 5'h08,
        A_AK = 5'h0C, A_SE = 5'h10, A_CE = 5'h14, A_VC = 5'h18, A_ME = 5'h1C;

    irq_vector_ctrl #(.NUM_IN(N), .EDGE_MASK(8'hF0), .ADDR_W(5)) uut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .irq_num(irq_num)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(string tag, logic [4:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset values
        rd("R1 status", A_ST, 0);
        rd("R1 pending", A_PD, 0);
        rd("R1 enable", A_EN, 0);
        rd("R1 vector", A_VC, 32'hFFFF_FFFF);
        rd("R1 master", A_ME, 0);
        chk("R1 irq_req", {31'b0, irq_req}, 0);

        // R4 capture while disabled
        irq_in = 8'h22; tick(); irq_in = 8'h00;
        rd("R4 status disabled", A_ST, 32'h22);
        rd("R4 pending", A_PD, 0);
        wr(A_AK, 32'hFFFF_FFFF);
        rd("R5 ack all", A_ST, 32'h02 & 32'h00);

        // R6 enable updates
        wr(A_EN, 32'h0F);
        rd("R6 load", A_EN, 32'h0F);
        wr(A_SE, 32'h30);
        rd("R6 set", A_EN, 32'h3F);
        wr(A_CE, 32'h05);
        rd("R6 clear", A_EN, 32'h3A);

        // R9 master gating, input 1 pending
        irq_in = 8'h02; tick(); irq_in = 8'h00; tick();
        wr(A_AK, 32'h0);
        rd("R7 pending", A_PD, 32'h02);
        for (int m = 0; m < 4; m++) begin
            wr(A_ME, m);
            #1;
            chk("R9 gate", {31'b0, irq_req}, (m == 3) ? 1 : 0);
        end
        rd("R9 master read", A_ME, 3);
        chk("R8 irq_num", {29'b0, irq_num}, 1);

        // R5 partial ack
        irq_in = 8'h00; wr(A_AK, 32'h0);
        irq_in = 8'h0A; tick(); irq_in = 8'h00; tick();
        wr(A_AK, 32'h02);
        rd("R5 partial ack", A_ST, 32'h08);
        wr(A_AK, 32'hFF);

        // R3 level reasserts after ack
        irq_in = 8'h01; tick();
        rd("R3 level set", A_ST, 32'h01);
        wr(A_AK, 32'h01);
        rd("R3 level held after ack", A_ST, 32'h01);
        irq_in = 8'h00; wr(A_AK, 32'h01);
        rd("R3 level cleared", A_ST, 0);

        // R2 edge needs new edge
        irq_in = 8'h10; tick();
        rd("R2 edge set", A_ST, 32'h10);
        wr(A_AK, 32'h10); tick();
        rd("R2 edge held no recapture", A_ST, 0);
        irq_in = 8'h00; tick(); irq_in = 8'h10; tick();
        rd("R2 new edge", A_ST, 32'h10);
        irq_in = 8'h00; wr(A_AK, 32'hFF);

        // R10 ignored writes and zero reads
        irq_in = 8'h20; tick(); irq_in = 8'h00;
        wr(A_ST, 32'hFF); wr(A_PD, 32'hFF); wr(A_VC, 32'hFF);
        rd("R10 status kept", A_ST, 32'h20);
        rd("R10 enable kept", A_EN, 32'h3A);
        rd("R10 ack reads 0", A_AK, 0);
        rd("R10 set reads 0", A_SE, 0);
        rd("R10 clear reads 0", A_CE, 0);
        wr(A_AK, 32'hFF);

        // Sweep all patterns: R7 R8 R9
        wr(A_EN, 32'hFF);
        for (int p = 0; p < 256; p++) begin
            logic [31:0] ev;
            ev = 32'hFFFF_FFFF;
            for (int j = N - 1; j >= 0; j--) if (p[j]) ev = j;
            irq_in = p[7:0]; tick();
            rd("R2 R3 sweep status", A_ST, p);
            rd("R7 sweep pending", A_PD, p);
            rd("R8 sweep vector", A_VC, ev);
            chk("R9 sweep req", {31'b0, irq_req}, (p != 0) ? 1 : 0);
            if (p != 0) chk("R8 sweep irq_num", {29'b0, irq_num}, ev);
            irq_in = 8'h00; wr(A_AK, 32'hFFFF_FFFF);
            rd("R5 sweep cleared", A_ST, 0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule